// File: doc/BRIEF.md
# String Load Sequencer

This block carries out one string-load operation, or a counted run of them. It fetches an element from memory at the current source index, writes the element into an accumulator, and then moves the index by a signed step. The step size follows the element width and its sign follows a direction flag. When repeat is enabled, the sequencer loops once for each element in a count register and decrements that count as each element completes. It stops when the count reaches zero.

A controller loads the operation parameters with a one-cycle start strobe, then waits for a done pulse and reads the final index, count and accumulator. Reads go out on a valid/ready request channel. The request stays valid, with address and size held, until the memory takes it. The block raises response-ready only after a request has been accepted, and it keeps response-ready high until response-valid arrives. Memory may therefore stall either phase for any number of cycles, and only one read is ever in flight. The address size picks between a short 16-bit index, which wraps inside its low half, and a full 32-bit index.

Top module: `strload_seq`

## Requirements
- R1: After reset, busy_o, done_o, rd_valid_o and rsp_ready_o are low, and index_o, count_o and acc_o are zero.
- R2: Width code 0 (byte) moves the index by +1 when dir_i is 0 and by -1 when dir_i is 1.
- R3: Width code 1 (word) moves the index by 2, and width codes 2 and 3 (doubleword) move it by 4. The sign follows the same direction rule as R2.
- R4: Each response supplies its element in the low bits of rsp_data_i. A byte load replaces acc_o[7:0], a word load replaces acc_o[15:0], and the upper accumulator bits keep the value of acc_i taken at start. A doubleword load replaces all 32 bits.
- R5: With rep_i low, exactly one read is made and count_o keeps the value of count_i.
- R6: With rep_i high and a nonzero count N, exactly N reads are made. count_o drops by one at each response, and the index advances N steps.
- R7: With rep_i high and count_i zero, no read is issued. done_o pulses in the cycle after start, and index_o and acc_o keep their start values.
- R8: When addr32_i is 0, only index bits [15:0] step, wrapping modulo 65536, and bits [31:16] are held. rd_addr_o then carries the index's low 16 bits with its upper bits zero. When addr32_i is 1, the full 32-bit index steps and wraps modulo 2^32.
- R9: While rd_valid_o is high and rd_ready_i is low, rd_valid_o, rd_addr_o and rd_size_o hold their values. rsp_ready_o rises only after a request is accepted, and is never high together with rd_valid_o.
- R10: index_o, count_o and acc_o change only on a response handshake, which is rsp_valid_i and rsp_ready_o both high. rsp_data_i is ignored at all other times.
- R11: done_o is a one-cycle pulse, raised in the cycle after the last response handshake, with busy_o low. A start strobe arriving while busy_o is high is ignored.
- R12: Each read's rd_addr_o equals the index in effect before that element's step, and rd_size_o equals the width code.

Width code: 0 byte, 1 word, 2 or 3 doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that begins an operation when idle |
| width_i | input | 2 | Element width code |
| dir_i | input | 1 | 0 steps the index upward, 1 steps it downward |
| rep_i | input | 1 | Repeat the load for count_i elements |
| addr32_i | input | 1 | 1 selects the 32-bit index, 0 selects the 16-bit index |
| index_i | input | 32 | Initial source index |
| count_i | input | 32 | Initial element count |
| acc_i | input | 32 | Initial accumulator value |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Memory accepts the read request |
| rd_addr_o | output | 32 | Read address |
| rd_size_o | output | 2 | Read width code |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_ready_o | output | 1 | Sequencer is waiting for read data |
| rsp_data_i | input | 32 | Read data, element in the low bits |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| index_o | output | 32 | Current index |
| count_o | output | 32 | Current count |
| acc_o | output | 32 | Accumulator |

## Verification
The assertions assume the memory follows the channel rules. It asserts response-valid only while response-ready is high and returns one response per accepted request, and it may stall either phase. The assertions also assume start and its parameters are sampled only when the sequencer is idle. The stimulus uses a responder that answers only an open request or response phase, with stall lengths of zero to two cycles that vary between operations. Junk is driven on the data bus outside the response beat. One start strobe is placed in the middle of a busy run with different parameters, and that run must finish unaffected.

// File: rtl/strload_pkg.sv
package strload_pkg;

  typedef enum logic [1:0] {
    EW_BYTE  = 2'd0,
    EW_WORD  = 2'd1,
    EW_DWORD = 2'd2,
    EW_DALT  = 2'd3
  } elem_w_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic [1:0] width;
    logic       dir;
    logic       rep;
    logic       addr32;
  } op_cfg_t;

  // log2 of the element size in lanes, with the spare code folded onto doubleword
  function automatic logic [1:0] size_log2(input logic [1:0] w);
    return (w == EW_DALT) ? 2'd2 : w;
  endfunction

endpackage

// File: rtl/strload_step.sv
module strload_step
  import strload_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int SHORT_W = 16
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       width_i,
  input  logic             dir_i,
  input  logic             addr32_i,
  output logic [IDX_W-1:0] next_o,
  output logic [IDX_W-1:0] addr_o
);
  localparam int HI_W = IDX_W - SHORT_W;

  logic [IDX_W-1:0]   mag;
  logic [IDX_W-1:0]   delta;
  logic [IDX_W-1:0]   long_next;
  logic [SHORT_W-1:0] short_next;

  always_comb begin
    mag   = IDX_W'(1) << size_log2(width_i);
    delta = dir_i ? (~mag + IDX_W'(1)) : mag;
  end

  assign long_next  = idx_i + delta;
  assign short_next = idx_i[SHORT_W-1:0] + delta[SHORT_W-1:0];

  generate
    if (HI_W > 0) begin : g_split
      assign next_o = addr32_i ? long_next : {idx_i[IDX_W-1:SHORT_W], short_next};
      assign addr_o = addr32_i ? idx_i : {{HI_W{1'b0}}, idx_i[SHORT_W-1:0]};
    end else begin : g_flat
      assign next_o = long_next;
      assign addr_o = idx_i;
    end
  endgenerate

endmodule

// File: rtl/strload_merge.sv
module strload_merge
  import strload_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] acc_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES:0] lanes_used;
  assign lanes_used = (LANES+1)'(1) << size_log2(width_i);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic take;
      assign take = ((LANES+1)'(l) < lanes_used);
      assign acc_o[l*LANE_W +: LANE_W] = take ? data_i[l*LANE_W +: LANE_W]
                                              : acc_i[l*LANE_W +: LANE_W];
    end
  endgenerate

endmodule

// File: rtl/strload_ctrl.sv
module strload_ctrl
  import strload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_run_i,
  input  logic last_i,
  input  logic rd_ready_i,
  input  logic rsp_valid_i,
  output logic rd_valid_o,
  output logic rsp_ready_o,
  output logic accept_o,
  output logic beat_o,
  output logic busy_o,
  output logic done_o
);
  seq_st_e state_q, state_d;
  logic    done_q, done_d;

  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign rd_valid_o  = (state_q == ST_REQ);
  assign rsp_ready_o = (state_q == ST_WAIT);
  assign beat_o      = rsp_ready_o && rsp_valid_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (zero_run_i) done_d  = 1'b1;
          else            state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (rd_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/strload_seq.sv
module strload_seq
  import strload_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int SHORT_W = 16,
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        width_i,
  input  logic              dir_i,
  input  logic              rep_i,
  input  logic              addr32_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [IDX_W-1:0]  rd_addr_o,
  output logic [1:0]        rd_size_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  index_o,
  output logic [IDX_W-1:0]  count_o,
  output logic [DATA_W-1:0] acc_o
);
  op_cfg_t           cfg_q;
  logic [IDX_W-1:0]  idx_q, cnt_q, idx_next;
  logic [DATA_W-1:0] acc_q, acc_next;
  logic              accept, beat, zero_run, last;

  assign zero_run = rep_i && (count_i == '0);
  assign last     = !cfg_q.rep || (cnt_q == IDX_W'(1));

  strload_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .zero_run_i (zero_run),
    .last_i     (last),
    .rd_ready_i (rd_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rd_valid_o (rd_valid_o),
    .rsp_ready_o(rsp_ready_o),
    .accept_o   (accept),
    .beat_o     (beat),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  strload_step #(.IDX_W(IDX_W), .SHORT_W(SHORT_W)) u_step (
    .idx_i   (idx_q),
    .width_i (cfg_q.width),
    .dir_i   (cfg_q.dir),
    .addr32_i(cfg_q.addr32),
    .next_o  (idx_next),
    .addr_o  (rd_addr_o)
  );

  strload_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
    .acc_i  (acc_q),
    .data_i (rsp_data_i),
    .width_i(cfg_q.width),
    .acc_o  (acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      cfg_q <= '{width: width_i, dir: dir_i, rep: rep_i, addr32: addr32_i};
      idx_q <= index_i;
      cnt_q <= count_i;
      acc_q <= acc_i;
    end else if (beat) begin
      idx_q <= idx_next;
      acc_q <= acc_next;
      if (cfg_q.rep) cnt_q <= cnt_q - IDX_W'(1);
    end
  end

  assign rd_size_o = cfg_q.width;
  assign index_o   = idx_q;
  assign count_o   = cnt_q;
  assign acc_o     = acc_q;

endmodule

// File: rtl/strload_seq_chk.sv
module strload_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        rep_i,
  input logic [31:0] count_i,
  input logic        rd_valid_o,
  input logic        rd_ready_i,
  input logic [31:0] rd_addr_o,
  input logic [1:0]  rd_size_o,
  input logic        rsp_valid_i,
  input logic        rsp_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] index_o,
  input logic [31:0] count_o,
  input logic [31:0] acc_o,
  input logic        mode32
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o) && $stable(rd_size_o)); // R9

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && rsp_ready_o)); // R9

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready_o) |-> $past(rd_valid_o && rd_ready_i)); // R9

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(rsp_valid_i && rsp_ready_o) |=> $stable(index_o) && $stable(count_o) && $stable(acc_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11

  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && rep_i && count_i == 32'd0 |=> done_o && !busy_o && !rd_valid_o); // R7

  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !mode32 |-> rd_addr_o[31:16] == 16'd0); // R8

endmodule

bind strload_seq strload_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rep_i      (rep_i),
  .count_i    (count_i),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .rd_size_o  (rd_size_o),
  .rsp_valid_i(rsp_valid_i),
  .rsp_ready_o(rsp_ready_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .index_o    (index_o),
  .count_o    (count_o),
  .acc_o      (acc_o),
  .mode32     (cfg_q.addr32)
);

// File: tb/strload_seq_bench.sv
module strload_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  width_i = '0;
  logic        dir_i = 1'b0, rep_i = 1'b0, addr32_i = 1'b0;
  logic [31:0] index_i = '0, count_i = '0, acc_i = '0;
  logic        rd_valid_o, rd_ready_i = 1'b0;
  logic [31:0] rd_addr_o;
  logic [1:0]  rd_size_o;
  logic        rsp_valid_i = 1'b0, rsp_ready_o;
  logic [31:0] rsp_data_i = '0;
  logic        busy_o, done_o;
  logic [31:0] index_o, count_o, acc_o;

  int checks = 0, fails = 0, cycles = 0, op_no = 0;

  always #10 clk = ~clk;

  strload_seq u_strload_seq (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h5A, ~a[7:0], a[7:0] ^ a[15:8]};
  endfunction

  task automatic run_op(input logic [1:0] w, input logic d, input logic r,
                        input logic a32, input logic [31:0] idx0,
                        input logic [31:0] cnt0, input logic [31:0] acc0,
                        input logic poke);
    logic [31:0] m_idx, m_cnt, m_acc, last_addr, mag, dat;
    int reads, exp_reads, dly, waitc, iter;
    string stag;
    bit seen;
    m_idx = idx0; m_cnt = cnt0; m_acc = acc0; last_addr = '0;
    reads = 0; waitc = 0; seen = 0;
    dly = op_no % 3;
    op_no++;
    mag = 32'd1 << ((w == 2'd3) ? 2 : w);
    stag = (w == 2'd0) ? "R2" : "R3";
    @(negedge clk);
    width_i = w; dir_i = d; rep_i = r; addr32_i = a32;
    index_i = idx0; count_i = cnt0; acc_i = acc0; start_i = 1'b1;
    for (iter = 0; iter < 400; iter++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && iter == 2) begin
        // R11: strobe while busy with other parameters must be ignored
        start_i = 1'b1; index_i = 32'h0BAD_0BAD; width_i = 2'd0; rep_i = 1'b0;
      end
      rd_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = 32'hDEAD_BEEF;
      if (done_o) begin seen = 1; break; end
      if (rd_valid_o) begin
        if (waitc >= dly) begin
          rd_ready_i = 1'b1; reads++; waitc = 0;
          last_addr = a32 ? m_idx : {16'd0, m_idx[15:0]};
          check("R12 addr", rd_addr_o, last_addr);
          check("R12 size", {30'd0, rd_size_o}, {30'd0, w});
        end else waitc++;
      end else if (rsp_ready_o) begin
        if (waitc >= dly) begin
          rsp_valid_i = 1'b1; waitc = 0;
          dat = memf(last_addr);
          rsp_data_i = dat;
          case (w)
            2'd0:    m_acc = {m_acc[31:8], dat[7:0]};
            2'd1:    m_acc = {m_acc[31:16], dat[15:0]};
            default: m_acc = dat;
          endcase
          if (a32) m_idx = d ? m_idx - mag : m_idx + mag;
          else m_idx[15:0] = d ? m_idx[15:0] - mag[15:0] : m_idx[15:0] + mag[15:0];
          if (r) m_cnt = m_cnt - 1;
        end else waitc++;
      end
    end
    exp_reads = r ? int'(cnt0) : 1;
    check("R11 done seen", {31'd0, seen}, 32'd1);
    check("R11 busy at done", {31'd0, busy_o}, 32'd0);
    if (r && cnt0 == 0) begin
      check("R7 reads", reads, 0);
      check("R7 index", index_o, idx0);
      check("R7 acc", acc_o, acc0);
    end else begin
      check(r ? "R6 reads" : "R5 reads", reads, exp_reads);
      check(a32 ? {stag, " R8 index32"} : {stag, " R8 index16"}, index_o, m_idx);
      check("R4 acc", acc_o, m_acc);
    end
    check(r ? "R6 count" : "R5 count", count_o, r ? 32'd0 : cnt0);
    @(negedge clk);
    start_i = 1'b0;
    check("R11 done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] idx0;
    logic [31:0] cn;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid_o}, 32'd0);
    check("R1 rsp_ready", {31'd0, rsp_ready_o}, 32'd0);
    check("R1 index", index_o, 32'd0);
    check("R1 count", count_o, 32'd0);
    check("R1 acc", acc_o, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 2; a++)
      for (int w = 0; w < 4; w++)
        for (int d = 0; d < 2; d++)
          for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++) begin
              cn = (c == 0) ? 32'd0 : (c == 1) ? 32'd1 : 32'd3;
              if (a == 1) idx0 = d ? 32'h0000_0002 : 32'hFFFF_FFFD;
              else        idx0 = d ? 32'h1234_0001 : 32'hABCD_FFFE;
              run_op(2'(w), d[0], r[0], a[0], idx0, cn,
                     32'h8877_6655 ^ {w[7:0], c[7:0], d[7:0], r[7:0]},
                     (r == 1 && c == 2 && w == 1));
            end
    // long repeat run across the short wrap in both directions
    run_op(2'd2, 1'b0, 1'b1, 1'b0, 32'h5555_FFF0, 32'd9, 32'h0, 1'b0);
    run_op(2'd1, 1'b1, 1'b1, 1'b0, 32'h5555_0006, 32'd7, 32'h0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule